// File: doc/BRIEF.md
# Iterative Shift-Add Multiplier with Selectable Serial Bit Order

This block multiplies two unsigned WIDTH-bit numbers over WIDTH clocks. One factor is applied as a parallel word and stays fixed for the whole run. The other factor arrives one bit per clock on a single serial pin. On every clock the current serial bit chooses one of two addends: the whole parallel word or zero. That addend is merged into a 2*WIDTH-bit accumulator, which also moves one bit position per step.

A pulse on `start` clears the accumulator, loads a bit counter and records the bit order given on `msb_first`. With most-significant-bit-first order, the accumulator shifts left and the addend enters at the low end. With least-significant-bit-first order, the addend is added into the upper half and the accumulator then shifts right. After exactly WIDTH serial bits the block raises `done`. The product then holds until the next `start`. No sign extension is needed, so a run always takes WIDTH cycles. While a run is in progress, `product` shows the partial accumulator.

Top module: `shiftadd_mul`

## Requirements
- R1: After reset, and until the first `start`, `product` is zero and `done` is low.
- R2: A clock edge with `start` high clears `product` to zero and drops `done` on the next cycle. It also samples `msb_first` (1 = most significant bit first, 0 = least significant bit first) for the run. The serial bit present in that cycle is not used.
- R3: On each of the WIDTH clocks after `start`, a serial bit of 1 adds `opnd` and a serial bit of 0 adds zero. A zero bit therefore only shifts `product`: left by one bit in MSB-first order, right by one bit in LSB-first order.
- R4: In MSB-first order, `product` after i bits equals `opnd` times the value of the i bits received so far, where the first bit received is the most significant.
- R5: In LSB-first order, `product` after i bits equals `opnd` times the value of the i bits received so far, with the first bit received being bit 0, multiplied by 2^(WIDTH-i).
- R6: `done` rises exactly WIDTH clocks after the `start` edge and not before. At that point `product` equals the full 2*WIDTH-bit product, with no loss even for all-ones operands.
- R7: Once `done` is high and `start` is low, `done` and `product` hold, whatever the serial input does.
- R8: A `start` during a run abandons that run and begins a new one from a cleared accumulator.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Begin a new multiplication |
| msb_first | input | 1 | Serial bit order, sampled with `start` (1 = MSB first) |
| opnd | input | WIDTH | Parallel factor, held for the run |
| ser_bit | input | 1 | Serial factor, one bit per clock |
| product | output | 2*WIDTH | Accumulator; the full product once `done` is high |
| done | output | 1 | Run complete, product valid |

## Verification
The checks assume that `opnd` stays unchanged from the `start` cycle to the last serial bit of a run. They also assume that `start` is not raised during the two clocks in which the internal reset is still being released. The stimulus follows both rules. It changes `opnd` only in the cycle that carries `start`, and it waits several clocks after reset before the first run. Runs that are restarted mid-way still present a stable operand from their own `start` onward. The serial pin is toggled freely while `done` holds, to show that it has no effect there.

// File: rtl/shmul_pkg.sv
package shmul_pkg;
  typedef enum logic {
    ORDER_LSB = 1'b0,
    ORDER_MSB = 1'b1
  } bit_order_e;
endpackage

// File: rtl/shmul_rst_sync.sv
module shmul_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign srst_n = sync_q[1];
endmodule

// File: rtl/shmul_seq.sv
module shmul_seq #(
  parameter int WIDTH = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic step,
  output logic done
);
  localparam int CW = $clog2(WIDTH + 1);
  localparam logic [CW-1:0] LOAD = CW'(WIDTH);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          done_q, done_d;
  logic          busy;

  assign busy = (cnt_q != '0);

  always_comb begin
    cnt_d  = cnt_q;
    done_d = done_q;
    if (start) begin
      cnt_d  = LOAD;
      done_d = 1'b0;
    end else if (busy) begin
      cnt_d = cnt_q - 1'b1;
      if (cnt_q == CW'(1)) done_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      done_q <= done_d;
    end
  end

  assign step = busy && !start;
  assign done = done_q;
endmodule

// File: rtl/shmul_acc.sv
module shmul_acc
  import shmul_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             step,
  input  bit_order_e       order,
  input  logic [WIDTH-1:0] opnd,
  input  logic             ser_bit,
  output logic [2*WIDTH-1:0] acc
);
  localparam int PW = 2 * WIDTH;

  logic [PW-1:0]    acc_q, acc_d, up_next, down_next;
  logic [WIDTH-1:0] addend;
  logic [WIDTH:0]   hi_sum;
  logic             acc_en;

  assign addend = ser_bit ? opnd : '0;

  // MSB first: shift left, then add at the low end
  assign up_next = {acc_q[PW-2:0], 1'b0} + {{WIDTH{1'b0}}, addend};

  // LSB first: add into the upper half, then shift right by one
  assign hi_sum    = {1'b0, acc_q[PW-1:WIDTH]} + {1'b0, addend};
  assign down_next = {hi_sum, acc_q[WIDTH-1:1]};

  assign acc_en = clr | step;

  always_comb begin
    if (clr)                     acc_d = '0;
    else if (order == ORDER_MSB) acc_d = up_next;
    else                         acc_d = down_next;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      acc_q <= '0;
    else if (acc_en) acc_q <= acc_d;
  end

  assign acc = acc_q;
endmodule

// File: rtl/shiftadd_mul.sv
module shiftadd_mul
  import shmul_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic               msb_first,
  input  logic [WIDTH-1:0]   opnd,
  input  logic               ser_bit,
  output logic [2*WIDTH-1:0] product,
  output logic               done
);
  logic       rst_sync_n;
  logic       step;
  bit_order_e order_q, order_d;

  shmul_rst_sync u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (rst_sync_n)
  );

  always_comb begin
    order_d = order_q;
    if (start) order_d = msb_first ? ORDER_MSB : ORDER_LSB;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) order_q <= ORDER_MSB;
    else if (start)  order_q <= order_d;
  end

  shmul_seq #(.WIDTH(WIDTH)) u_seq (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .start (start),
    .step  (step),
    .done  (done)
  );

  shmul_acc #(.WIDTH(WIDTH)) u_acc (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .clr     (start),
    .step    (step),
    .order   (order_q),
    .opnd    (opnd),
    .ser_bit (ser_bit),
    .acc     (product)
  );
endmodule

// File: rtl/shiftadd_mul_chk.sv
module shiftadd_mul_chk #(
  parameter int WIDTH = 8
) (
  input logic               clk,
  input logic               rst_ok,
  input logic               start,
  input logic               msb_first,
  input logic [WIDTH-1:0]   opnd,
  input logic               ser_bit,
  input logic [2*WIDTH-1:0] product,
  input logic               done
);
  localparam int CW = $clog2(WIDTH + 1);

  logic [CW-1:0] left_q;
  logic          mode_q;

  always_ff @(posedge clk or negedge rst_ok) begin
    if (!rst_ok) begin
      left_q <= '0;
      mode_q <= 1'b1;
    end else if (start) begin
      left_q <= CW'(WIDTH);
      mode_q <= msb_first;
    end else if (left_q != '0) begin
      left_q <= left_q - 1'b1;
    end
  end

  // R2
  a_r2_start_clears: assert property (@(posedge clk) disable iff (!rst_ok)
    start |=> (product == '0 && !done));

  // R3: a zero bit only shifts the accumulator
  a_r3_zero_bit_shift: assert property (@(posedge clk) disable iff (!rst_ok)
    (left_q != '0 && !start && !ser_bit) |=>
      (product == ($past(mode_q) ? ($past(product) << 1) : ($past(product) >> 1))));

  // R3: the operand is held for the whole run (input rule)
  a_r3_opnd_held: assert property (@(posedge clk) disable iff (!rst_ok)
    (left_q != '0 && !start) |-> $stable(opnd));

  // R6
  a_r6_done_on_last: assert property (@(posedge clk) disable iff (!rst_ok)
    (left_q == CW'(1) && !start) |=> done);

  a_r6_no_early_done: assert property (@(posedge clk) disable iff (!rst_ok)
    (left_q > CW'(1) && !start) |=> !done);

  // R7
  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_ok)
    (done && !start) |=> (done && $stable(product)));
endmodule

bind shiftadd_mul shiftadd_mul_chk #(.WIDTH(WIDTH)) u_chk (
  .clk       (clk),
  .rst_ok    (rst_sync_n),
  .start     (start),
  .msb_first (msb_first),
  .opnd      (opnd),
  .ser_bit   (ser_bit),
  .product   (product),
  .done      (done)
);

// File: tb/sim_shiftadd_mul.sv
module sim_shiftadd_mul;
  localparam int W = 8;
  localparam longint PMASK = (64'd1 << (2 * W)) - 1;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             start = 1'b0;
  logic             msb_first = 1'b1;
  logic [W-1:0]     opnd = '0;
  logic             ser_bit = 1'b0;
  logic [2*W-1:0]   product;
  logic             done;

  int checks = 0;
  int fails  = 0;

  // reference model state
  longint m_a, m_val;
  int     m_i, m_left;
  bit     m_mode, m_done;

  always #10 clk = ~clk;

  shiftadd_mul #(.WIDTH(W)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .msb_first(msb_first),
    .opnd(opnd), .ser_bit(ser_bit), .product(product), .done(done)
  );

  function automatic longint exp_prod();
    longint p;
    p = m_a * m_val;
    if (!m_mode) p = p << (W - m_i);
    return p & PMASK;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_a = 0; m_val = 0; m_i = 0; m_left = 0; m_mode = 1; m_done = 0;
    end else if (start) begin
      m_a = opnd; m_val = 0; m_i = 0; m_left = W; m_mode = msb_first; m_done = 0;
    end else if (m_left > 0) begin
      if (m_mode) m_val = m_val * 2 + ser_bit;
      else        m_val = m_val + (longint'(ser_bit) << m_i);
      m_i++;
      m_left--;
      if (m_left == 0) m_done = 1;
    end
  end

  task automatic check(string tag, longint act, longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // cycle-by-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n) begin
      string tag;
      tag = m_done ? "R7" : (m_left == 0 ? "R1" : (m_mode ? "R4" : "R5"));
      check(tag, longint'(product), exp_prod());
      check({tag, "_done"}, longint'(done), longint'(m_done));
    end
  end

  task automatic begin_run(input logic [W-1:0] a, input bit msb);
    @(negedge clk);
    start = 1'b1; msb_first = msb; opnd = a; ser_bit = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check("R2", longint'(product), 0);
    check("R2_done", longint'(done), 0);
  endtask

  task automatic feed(input logic [W-1:0] b, input bit msb, input int nbits);
    for (int i = 0; i < nbits; i++) begin
      ser_bit = msb ? b[W-1-i] : b[i];
      @(negedge clk);
      if (i < W - 1) check("R6_early", longint'(done), 0);
    end
  endtask

  task automatic full_run(input logic [W-1:0] a, input logic [W-1:0] b, input bit msb);
    begin_run(a, msb);
    feed(b, msb, W);
    check(msb ? "R4_final" : "R5_final", longint'(product), longint'(a) * longint'(b));
    check("R6", longint'(done), 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1", longint'(product), 0);
    check("R1_done", longint'(done), 0);

    // R4 MSB-first patterns
    full_run(8'hFF, 8'hFF, 1'b1);
    full_run(8'h00, 8'hA5, 1'b1);
    full_run(8'h37, 8'h80, 1'b1);
    full_run(8'h81, 8'h01, 1'b1);
    // R5 LSB-first patterns
    full_run(8'hFF, 8'hFF, 1'b0);
    full_run(8'hC3, 8'h01, 1'b0);
    full_run(8'h5A, 8'h80, 1'b0);
    full_run(8'h12, 8'h00, 1'b0);
    // R3: zero operand bits alternating
    full_run(8'h9B, 8'h55, 1'b1);
    full_run(8'h9B, 8'hAA, 1'b0);

    // R7: serial pin toggles while done holds
    full_run(8'hE7, 8'h3C, 1'b1);
    for (int k = 0; k < 6; k++) begin
      ser_bit = k[0];
      @(negedge clk);
      check("R7_hold", longint'(product), longint'(8'hE7) * 8'h3C);
      check("R7_done", longint'(done), 1);
    end

    // R8: restart part-way through a run
    begin_run(8'hFF, 1'b1);
    feed(8'hFF, 1'b1, 3);
    full_run(8'h6D, 8'hB1, 1'b0);
    check("R8", longint'(product), longint'(8'h6D) * 8'hB1);
    begin_run(8'h44, 1'b0);
    feed(8'h77, 1'b0, 5);
    full_run(8'h2F, 8'hD9, 1'b1);
    check("R8", longint'(product), longint'(8'h2F) * 8'hD9);

    for (int n = 0; n < 20; n++) begin
      logic [W-1:0] ra, rb;
      ra = W'($urandom);
      rb = W'($urandom);
      full_run(ra, rb, n[0]);
    end

    repeat (2) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule